// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is one timer channel with a small register interface. A counter runs from a selectable tick source. The source is one of four power-of-two divisions of the system clock, a slow reference input, or an external chained input. The counter either runs freely and wraps at its full width, or returns to zero after it reaches a compare value held in the RC register. If the stop option is set, the channel switches off its own counting when that compare is reached, which gives a one-shot delay.

A second compare value, RA, works with RC to set and clear an output pin. Used with a free-running counter, the pin gives a programmable square wave. Compare and wrap events set sticky status flags. Any flag whose mask bit is set drives a level interrupt.

Software starts and stops counting through write-one command bits. It restarts the count with a trigger command. It sets and clears interrupt mask bits through separate write-one registers.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter is 0, counting is stopped, RA, RC, mode and mask are 0, the pin is low and the interrupt is low.
- R2: Address 0 is a command register. Writing 1 to bit 0 starts counting and writing 1 to bit 1 stops it; if both bits are 1, stop wins. Bit 8 of the status register (address 5) reads 1 while counting is on. While counting is off the counter holds its value.
- R3: Writing 1 to bit 2 of the command register sets the counter and the divider to 0 at the next edge. The counter then counts only if counting is on.
- R4: With mode bit 3 clear (address 1), the counter wraps from all ones to 0. That wrap sets status bit 2.
- R5: With mode bit 3 set, a tick taken while the counter equals RC (address 3) returns it to 0, so one period is RC+1 ticks. A tick that brings the counter to RC sets status bit 0.
- R6: With mode bit 4 set, the tick that brings the counter to RC also stops counting. The counter then holds RC until counting is started again.
- R7: With mode bit 5 set, the pin goes high when the counter reaches RA (address 2). With mode bit 6 set, the pin goes low when the counter reaches RC. When both happen on the same tick, low wins. Reaching RA sets status bit 1.
- R8: Writing ones to address 6 sets mask bits [2:0], and reading address 6 returns the mask. Writing ones to address 7 clears mask bits. The interrupt is high exactly while a status flag and its mask bit are both 1.
- R9: Reading the status register clears flags [2:0]. A flag whose event occurs in the same cycle as the read stays set.
- R10: Mode bits [2:0] select the tick source. Values 0 to 3 give the system clock divided by 2, 8, 32 and 128. Value 4 ticks on rising edges of slow_in, value 5 ticks on rising edges of ext_in, and values 6 and 7 give no ticks.
- R11: The counter value (address 4) is read-only; writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 5) |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr, combinational |
| slow_in | input | 1 | Slow reference clock, edge-detected |
| ext_in | input | 1 | Chained external clock, edge-detected |
| pin_out | output | 1 | Compare-driven output pin |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches several properties on every cycle. The counter must not move while counting is off, except through a command write. A one-shot must be stopped once the counter reaches RC. The pin may change only after the matching compare event. A status read must leave the flags empty when no event arrived with it. The interrupt must stay low while the mask is empty. Only the bench scenarios can show the actual count sequences: the wrap point, the RC+1 period for a sweep of RC values, each divider ratio, the choice between the slow and external inputs, the read-only counter, and the flag that survives a read arriving together with its event.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_RA   = 3'd2;
    localparam logic [2:0] A_RC   = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;
    localparam logic [2:0] A_IEN  = 3'd6;
    localparam logic [2:0] A_IDIS = 3'd7;

    localparam int CMD_ON   = 0;
    localparam int CMD_OFF  = 1;
    localparam int CMD_TRIG = 2;
    localparam int STAT_RUN = 8;

    typedef struct packed {
        logic       pin_clr;
        logic       pin_set;
        logic       stop;
        logic       auto_rst;
        logic [2:0] sel;
    } mode_t;

    typedef struct packed {
        logic wrap;
        logic ra;
        logic rc;
    } evt_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int DIV_LOG0 = 1,
    parameter int DIV_STEP = 2,
    parameter int N_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [2:0] sel,
    input  logic       slow_in,
    input  logic       ext_in,
    output logic       tick
);
    localparam int PRE_W = DIV_LOG0 + DIV_STEP * (N_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             slow;
        logic             ext;
    } pst_t;

    pst_t s_d, s_q;
    logic [N_DIV-1:0] div_tick;

    for (genvar i = 0; i < N_DIV; i++) begin : g_div
        localparam int L = DIV_LOG0 + DIV_STEP * i;
        assign div_tick[i] = &s_q.pre[L-1:0];
    end

    always_comb begin
        s_d      = s_q;
        s_d.pre  = trig ? '0 : s_q.pre + 1'b1;
        s_d.slow = slow_in;
        s_d.ext  = ext_in;
        tick     = 1'b0;
        for (int i = 0; i < N_DIV; i++) begin
            if (sel == 3'(i)) tick = div_tick[i];
        end
        if (sel == 3'(N_DIV))     tick = slow_in & ~s_q.slow;
        if (sel == 3'(N_DIV + 1)) tick = ext_in & ~s_q.ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clk_on,
    input  logic         clk_off,
    input  logic         trig,
    input  logic         auto_rst,
    input  logic         stop,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rc,
    output logic [W-1:0] cnt,
    output logic         running,
    output evt_t         evt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
    } cst_t;

    cst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        evt = '0;
        if (trig) begin
            s_d.cnt = '0;
        end else if (s_q.run && tick) begin
            if (auto_rst && s_q.cnt == rc) s_d.cnt = '0;
            else                           s_d.cnt = s_q.cnt + 1'b1;
            evt.wrap = !auto_rst && (s_q.cnt == CNT_MAX);
            evt.ra   = (s_d.cnt == ra);
            evt.rc   = (s_d.cnt == rc);
        end
        if (clk_on)          s_d.run = 1'b1;
        if (evt.rc && stop)  s_d.run = 1'b0;
        if (clk_off)         s_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign running = s_q.run;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_LOG0 = 1,
    parameter int DIV_STEP = 2,
    parameter int N_DIV    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             slow_in,
    input  logic             ext_in,
    output logic             pin_out,
    output logic             irq
);
    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] ra;
        logic [CNT_W-1:0] rc;
        logic [2:0]       mask;
        logic [2:0]       flags;
        logic             pin;
    } rst_t;

    rst_t s_d, s_q;
    logic ctrl_wr, stat_rd, tick, running;
    logic [CNT_W-1:0] cnt;
    evt_t evt;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign stat_rd = rd_en && (addr == A_STAT);

    tmr_prescale #(.DIV_LOG0(DIV_LOG0), .DIV_STEP(DIV_STEP), .N_DIV(N_DIV)) i_pre (
        .clk(clk), .rst_n(rst_n), .trig(ctrl_wr && wdata[CMD_TRIG]),
        .sel(s_q.mode.sel), .slow_in(slow_in), .ext_in(ext_in), .tick(tick)
    );

    tmr_core #(.W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .clk_on(ctrl_wr && wdata[CMD_ON]), .clk_off(ctrl_wr && wdata[CMD_OFF]),
        .trig(ctrl_wr && wdata[CMD_TRIG]),
        .auto_rst(s_q.mode.auto_rst), .stop(s_q.mode.stop),
        .ra(s_q.ra), .rc(s_q.rc), .cnt(cnt), .running(running), .evt(evt)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (addr)
                A_MODE:  s_d.mode = mode_t'(wdata[6:0]);
                A_RA:    s_d.ra   = wdata;
                A_RC:    s_d.rc   = wdata;
                A_IEN:   s_d.mask = s_q.mask | wdata[2:0];
                A_IDIS:  s_d.mask = s_q.mask & ~wdata[2:0];
                default: ;
            endcase
        end
        s_d.flags = (stat_rd ? 3'b000 : s_q.flags) | evt;
        if (evt.ra && s_q.mode.pin_set) s_d.pin = 1'b1;
        if (evt.rc && s_q.mode.pin_clr) s_d.pin = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: rdata[6:0] = s_q.mode;
            A_RA:   rdata      = s_q.ra;
            A_RC:   rdata      = s_q.rc;
            A_CNT:  rdata      = cnt;
            A_STAT: begin
                rdata[2:0]     = s_q.flags;
                rdata[STAT_RUN] = running;
            end
            A_IEN:  rdata[2:0] = s_q.mask;
            default: ;
        endcase
    end

    assign pin_out = s_q.pin;
    assign irq     = |(s_q.flags & s_q.mask);
endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctrl_wr,
    input logic         stat_rd,
    input logic [W-1:0] cnt,
    input logic         running,
    input logic [2:0]   evt,
    input logic [2:0]   flags,
    input logic [2:0]   mask,
    input logic         stop,
    input logic [W-1:0] rc,
    input logic         pin,
    input logic         irq
);
    // R8
    no_irq_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 3'b000) |-> !irq);
    // R2
    cnt_held_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_wr) |=> $stable(cnt));
    // R6
    oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && rc != '0 && cnt == rc && cnt != $past(cnt)) |-> !running);
    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == 3'b000) |=> (flags == 3'b000));
    // R7
    pin_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin) |-> $past(evt[1]));
    // R7
    pin_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin) |-> $past(evt[0]));
endmodule

bind tmr_channel tmr_channel_chk #(.W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .cnt(cnt), .running(running), .evt(evt), .flags(s_q.flags),
    .mask(s_q.mask), .stop(s_q.mode.stop), .rc(s_q.rc), .pin(pin_out), .irq(irq)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
    localparam int W = 10;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, slow_in = 1'b0, ext_in = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic pin_out, irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_channel #(.CNT_W(W)) i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .slow_in(slow_in), .ext_in(ext_in),
        .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        addr = a; wdata = W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        int v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic ext_pulse();
        ext_in = 1'b1;
        @(negedge clk);
        ext_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic slow_pulse();
        slow_in = 1'b1;
        @(negedge clk);
        slow_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 cnt", 3'd4, 0);
        rd_chk("R1 stat", 3'd5, 0);
        rd_chk("R1 mask", 3'd6, 0);
        rd_chk("R1 mode", 3'd1, 0);
        rd_chk("R1 ra", 3'd2, 0);
        rd_chk("R1 rc", 3'd3, 0);
        chk("R1 pin", int'(pin_out), 0);
        chk("R1 irq", int'(irq), 0);

        // R10 external source, R3 trigger, R2 running status
        wr(3'd1, 'h05);
        wr(3'd0, 'h5);
        rd_chk("R2 running", 3'd5, 'h100);
        for (int k = 0; k < 10; k++) ext_pulse();
        rd_chk("R10 ext count", 3'd4, 10);
        // R11 counter is read-only
        wr(3'd4, 'h123);
        rd_chk("R11 cnt write ignored", 3'd4, 10);
        // R2 stop holds count
        wr(3'd0, 'h2);
        for (int k = 0; k < 3; k++) ext_pulse();
        rd_chk("R2 held", 3'd4, 10);
        rd_chk("R2 stopped", 3'd5, 0);
        wr(3'd0, 'h3);
        ext_pulse();
        rd_chk("R2 off wins", 3'd5, 0);
        // R3 trigger while stopped
        wr(3'd0, 'h4);
        ext_pulse();
        rd_chk("R3 trig stopped", 3'd4, 0);

        // R4 wrap at full width
        wr(3'd2, 0);
        wr(3'd3, 0);
        wr(3'd0, 'h5);
        for (int k = 0; k < 1023; k++) ext_pulse();
        rd_chk("R4 at max", 3'd4, 1023);
        rd(3'd5, v);
        ext_pulse();
        rd_chk("R4 wrapped", 3'd4, 0);
        rd_chk("R4 wrap flag", 3'd5, 'h107);
        rd_chk("R9 cleared", 3'd5, 'h100);

        // R5 up-to-compare sweep
        wr(3'd2, 'h3FF);
        for (int r = 1; r <= 6; r++) begin
            wr(3'd3, r);
            wr(3'd1, 'h0D);
            wr(3'd0, 'h5);
            for (int k = 1; k <= 2 * (r + 1); k++) begin
                ext_pulse();
                rd_chk("R5 period", 3'd4, k % (r + 1));
            end
        end

        // R6 one-shot
        wr(3'd0, 'h2);
        wr(3'd3, 3);
        wr(3'd1, 'h1D);
        rd(3'd5, v);
        wr(3'd0, 'h5);
        for (int k = 0; k < 3; k++) ext_pulse();
        rd_chk("R6 stop at rc", 3'd5, 'h001);
        for (int k = 0; k < 2; k++) ext_pulse();
        rd_chk("R6 hold rc", 3'd4, 3);
        wr(3'd3, 2);
        wr(3'd0, 'h5);
        for (int k = 0; k < 4; k++) ext_pulse();
        rd_chk("R6 second shot", 3'd4, 2);

        // R7 pin
        wr(3'd0, 'h2);
        wr(3'd1, 'h65);
        wr(3'd2, 2);
        wr(3'd3, 5);
        wr(3'd0, 'h5);
        for (int c = 1; c <= 5; c++) begin
            ext_pulse();
            chk("R7 pin", int'(pin_out), (c >= 2 && c < 5) ? 1 : 0);
        end
        wr(3'd2, 6);
        ext_pulse();
        chk("R7 pin set at ra", int'(pin_out), 1);
        wr(3'd2, 8);
        wr(3'd3, 8);
        ext_pulse();
        chk("R7 pin before tie", int'(pin_out), 1);
        ext_pulse();
        chk("R7 clear wins tie", int'(pin_out), 0);

        // R8 masking
        wr(3'd0, 'h2);
        wr(3'd1, 'h0D);
        wr(3'd2, 'h3FF);
        wr(3'd3, 2);
        rd(3'd5, v);
        wr(3'd0, 'h5);
        ext_pulse();
        ext_pulse();
        chk("R8 masked irq", int'(irq), 0);
        wr(3'd6, 'h1);
        chk("R8 irq on", int'(irq), 1);
        rd_chk("R8 mask read", 3'd6, 1);
        wr(3'd7, 'hFF);
        chk("R8 irq off", int'(irq), 0);
        rd_chk("R8 mask cleared", 3'd6, 0);
        // R9 clear on read, coincident event survives
        rd_chk("R9 flag", 3'd5, 'h101);
        rd_chk("R9 cleared", 3'd5, 'h100);
        ext_pulse();
        ext_pulse();
        addr = 3'd5; rd_en = 1'b1; ext_in = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0; ext_in = 1'b0;
        @(negedge clk);
        chk("R9 read value", v, 'h100);
        rd_chk("R9 coincident kept", 3'd5, 'h101);

        // R10 internal dividers
        for (int s = 0; s < 4; s++) begin
            int dv;
            dv = 1 << (1 + 2 * s);
            wr(3'd0, 'h2);
            wr(3'd1, s);
            wr(3'd0, 'h5);
            repeat (dv * 5 + dv - 1) @(negedge clk);
            rd_chk("R10 divider", 3'd4, 5);
        end
        // R10 slow input, ext ignored
        wr(3'd0, 'h2);
        wr(3'd1, 'h04);
        wr(3'd0, 'h5);
        for (int k = 0; k < 3; k++) ext_pulse();
        for (int k = 0; k < 4; k++) slow_pulse();
        rd_chk("R10 slow", 3'd4, 4);
        // R10 no source
        wr(3'd1, 'h06);
        wr(3'd0, 'h5);
        repeat (300) @(negedge clk);
        ext_pulse();
        rd_chk("R10 none", 3'd4, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule